// File: doc/BRIEF.md
# EEPROM Programming Sequence Controller

A byte-wide non-volatile array sits behind a simple CPU-style bus together with three byte registers: a programming control register, a live configuration register and a sticky error status register. Software never writes a stored byte directly. It sets the latch enable, writes one target (an array location, or the hidden configuration byte through the configuration register address), raises the programming voltage enable, waits, and then drops the voltage. The operation takes effect in the clock after the release. It either clears bits (AND with the latched byte) or erases one byte, a 16-byte aligned row, or the whole array to 0xFF.

A free-running cycle counter times the voltage pulse. A release earlier than `MIN_PULSE` cycles after the rising edge of the voltage enable still performs the operation, but it sets a sticky flag. Illegal sequences are not trapped. Each one sets its own status bit, which stays set until software writes 1 to it.

The configuration byte is stored one place past the last array location. The live configuration register copies it only at warm reset, and one of its bits (`EEON_BIT`) decides whether the array window answers the bus until the next warm reset. A separate storage reset models the erased state of a fresh part. The warm reset leaves the stored contents alone.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: While `rst_n` is low, the control register, the status register and the latched-write state clear. The live configuration register loads the stored configuration byte, or `CFG_INIT` if `pwr_rst_n` is also low. The array window is enabled for the following cycles only if bit `EEON_BIT` (bit 0 by default) of that loaded value is 1.
- R2: A control write (`bus_space`=1) that newly sets both bit 1 (latch enable) and bit 0 (voltage enable) in one write is rejected. The control register keeps its value and status bit 0 is set.
- R3: Control register bits are: bit 0 voltage enable, bit 1 latch enable, bit 2 erase, bit 3 row, bit 4 byte. Bits 7:5 read as 0. Any accepted control write with bit 1 clear stores 0, so bit 0 is never set while bit 1 is clear.
- R4: An array write (`bus_space`=0) or configuration write (`bus_space`=2) with latch enable set and nothing latched captures the target and data byte. A further such write while a write is latched is ignored and sets status bit 3. Such a write with latch enable clear is ignored and sets status bit 2.
- R5: An array read with latch enable set sets status bit 4, and the stored byte is still returned.
- R6: An accepted control write with bit 0 set while nothing is latched sets status bit 1. A voltage release with nothing latched changes no stored byte.
- R7: A 0-to-1 change of bit 0 captures the cycle counter. The 1-to-0 change (release) compares the elapsed count with `MIN_PULSE`. If it is shorter, status bit 5 is set and the operation is still applied. The release always clears the latched-write state.
- R8: On release with erase (bit 2) clear, the target byte becomes its old value ANDed with the latched byte.
- R9: On release with erase set, the target alone becomes 0xFF when bit 4 (byte) is set or the target is the configuration byte.
- R10: On release with erase set, byte clear, row (bit 3) set and an array target, the 16 locations sharing the target's address bits above bit 3 become 0xFF and all others keep their values.
- R11: On release with erase set, byte and row clear and an array target, every array location becomes 0xFF. The stored configuration byte is not changed.
- R12: Reading `bus_space`=2 returns the live configuration value, which changes only at warm reset. While the window is disabled, array reads return 0x00 and array writes are ignored with no flag.
- R13: Status bits hold until a write to `bus_space`=3 with 1 in the same bit position. Bits 7:6 read as 0.
- R14: `pwr_rst_n` low sets every array location to 0xFF and the configuration byte to `CFG_INIT`. A warm reset alone keeps all stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Storage reset, active low: blank array and configuration byte |
| rst_n | input | 1 | Warm reset, active low, synchronous |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_space | input | 2 | 0 array, 1 control, 2 configuration, 3 status |
| bus_addr | input | ADDR_W | Array location for `bus_space`=0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected space and address, combinational |

## Verification
The assertions assume at most one access per cycle on a bus whose inputs are settled at the sampling edge. They also assume that `pwr_rst_n` is never low while `rst_n` is high. The bench changes every input shortly after a rising edge, with an idle cycle between accesses. It lowers `pwr_rst_n` only together with `rst_n`, and it keeps the bus idle while either reset is low. The pulse-length checks depend on a reduced `MIN_PULSE`, so the bench's waits are counted against that parameter rather than the default.

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl #(
  parameter int          ADDR_W    = 6,
  parameter int          ROW_BYTES = 16,
  parameter int          MIN_PULSE = 10000,
  parameter int          CNT_W     = 24,
  parameter int          EEON_BIT  = 0,
  parameter logic [7:0]  CFG_INIT  = 8'hFF
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_space,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROW_W = $clog2(ROW_BYTES);
  localparam logic [1:0] SP_ARR = 2'd0, SP_CTL = 2'd1, SP_CFG = 2'd2, SP_STS = 2'd3;
  localparam int B_PGM = 0, B_LAT = 1, B_ERS = 2, B_ROW = 3, B_BYTE = 4;

  logic [7:0]        mem [DEPTH];
  logic [7:0]        cfg_mem, cfg_live;
  logic              win_en;
  logic [4:0]        ctrl_q, ctrl_nx;
  logic [5:0]        sts_q, sts_set, sts_clr;
  logic              lat_vld, lat_cfg;
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0]        lat_data;
  logic [CNT_W-1:0]  cnt_q, start_q, elapsed;
  logic [DEPTH-1:0]  hit;

  logic do_wr, do_rd, ctl_wr, sts_wr, arr_rd, data_wr;
  logic both_set, ctl_take, pgm_on, pgm_off, apply, lat_take;
  logic [1:0] unused_wd;

  assign unused_wd = bus_wdata[7:6];
  assign do_wr    = bus_valid & bus_write;
  assign do_rd    = bus_valid & ~bus_write;
  assign ctl_wr   = do_wr & (bus_space == SP_CTL);
  assign sts_wr   = do_wr & (bus_space == SP_STS);
  assign arr_rd   = do_rd & (bus_space == SP_ARR) & win_en;
  assign data_wr  = do_wr & (((bus_space == SP_ARR) & win_en) | (bus_space == SP_CFG));

  assign both_set = ctl_wr & (&(bus_wdata[1:0] & ~ctrl_q[1:0]));
  assign ctl_take = ctl_wr & ~both_set;
  assign ctrl_nx  = bus_wdata[B_LAT] ? bus_wdata[4:0] : 5'd0;
  assign pgm_on   = ctl_take &  ctrl_nx[B_PGM] & ~ctrl_q[B_PGM];
  assign pgm_off  = ctl_take & ~ctrl_nx[B_PGM] &  ctrl_q[B_PGM];
  assign apply    = rst_n & pgm_off & lat_vld;
  assign elapsed  = cnt_q - start_q;
  assign lat_take = data_wr & ctrl_q[B_LAT] & ~lat_vld;

  assign sts_set = {pgm_off & (elapsed < CNT_W'(MIN_PULSE)),
                    arr_rd & ctrl_q[B_LAT],
                    data_wr & ctrl_q[B_LAT] & lat_vld,
                    data_wr & ~ctrl_q[B_LAT],
                    ctl_take & ctrl_nx[B_PGM] & ~lat_vld,
                    both_set};
  assign sts_clr = sts_wr ? bus_wdata[5:0] : 6'd0;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_hit
      localparam logic [ADDR_W-1:0] IDX = ADDR_W'(gi);
      assign hit[gi] = (~ctrl_q[B_ERS] | ctrl_q[B_BYTE]) ? (lat_addr == IDX) :
                       ctrl_q[B_ROW] ? ((lat_addr >> ROW_W) == (IDX >> ROW_W)) : 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sts_q    <= '0;
      lat_vld  <= 1'b0;
      lat_cfg  <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
      cnt_q    <= '0;
      start_q  <= '0;
      cfg_live <= pwr_rst_n ? cfg_mem : CFG_INIT;
      win_en   <= pwr_rst_n ? cfg_mem[EEON_BIT] : CFG_INIT[EEON_BIT];
    end else begin
      cnt_q <= cnt_q + 1'b1;
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (ctl_take) ctrl_q <= ctrl_nx;
      if (pgm_on) start_q <= cnt_q;
      if (pgm_off) lat_vld <= 1'b0;
      else if (lat_take) begin
        lat_vld  <= 1'b1;
        lat_cfg  <= (bus_space == SP_CFG);
        lat_addr <= bus_addr;
        lat_data <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!pwr_rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      cfg_mem <= CFG_INIT;
    end else if (apply) begin
      if (lat_cfg)
        cfg_mem <= ctrl_q[B_ERS] ? 8'hFF : (cfg_mem & lat_data);
      else
        for (int i = 0; i < DEPTH; i++)
          if (hit[i]) mem[i] <= ctrl_q[B_ERS] ? 8'hFF : (mem[i] & lat_data);
    end
  end

  always_comb begin
    case (bus_space)
      SP_ARR:  bus_rdata = win_en ? mem[bus_addr] : 8'h00;
      SP_CTL:  bus_rdata = {3'b000, ctrl_q};
      SP_CFG:  bus_rdata = cfg_live;
      default: bus_rdata = {2'b00, sts_q};
    endcase
  end
endmodule

module eeprom_prog_ctrl_chk (
  input logic       clk,
  input logic       pwr_rst_n,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       bus_write,
  input logic [1:0] bus_space,
  input logic [1:0] ctl_wd,
  input logic [4:0] ctrl_q,
  input logic [5:0] sts_q,
  input logic       lat_vld,
  input logic       win_en
);
  logic ctl_w, sts_w, data_w, arr_r;
  assign ctl_w  = bus_valid & bus_write & (bus_space == 2'd1);
  assign sts_w  = bus_valid & bus_write & (bus_space == 2'd3);
  assign data_w = bus_valid & bus_write & ((bus_space == 2'd2) | ((bus_space == 2'd0) & win_en));
  assign arr_r  = bus_valid & ~bus_write & (bus_space == 2'd0) & win_en;

  assert_warm_reset_R1: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !rst_n |=> (ctrl_q == 5'd0) && (sts_q == 6'd0) && !lat_vld);

  assert_both_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w && (ctl_wd == 2'b11) && (ctrl_q[1:0] == 2'b00) |=> $stable(ctrl_q) && sts_q[0]);

  assert_no_latch_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w && !ctl_wd[1] |=> ctrl_q == 5'd0);

  assert_pgm_under_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] |-> ctrl_q[1]);

  assert_second_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lat_vld && data_w && ctrl_q[1] |=> lat_vld && sts_q[3]);

  assert_read_while_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_r && ctrl_q[1] |=> sts_q[4]);

  assert_sticky_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_w |=> (sts_q & $past(sts_q)) == $past(sts_q));
endmodule

bind eeprom_prog_ctrl eeprom_prog_ctrl_chk u_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_space(bus_space), .ctl_wd(bus_wdata[1:0]),
  .ctrl_q(ctrl_q), .sts_q(sts_q), .lat_vld(lat_vld), .win_en(win_en)
);

// File: tb/eeprom_prog_ctrl_tb.sv
module eeprom_prog_ctrl_tb_top;
  localparam int AW = 6, N = 64, MINP = 64;

  logic clk = 0, pwr_rst_n = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [1:0] bus_space = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  eeprom_prog_ctrl #(.ADDR_W(AW), .ROW_BYTES(16), .MIN_PULSE(MINP), .CNT_W(24)) dut_i (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_space(bus_space), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #10 clk = ~clk;

  // reference model state
  int mm [0:N];
  int mctrl, msts, mlat, mladdr, mlcfg, mldata, mcnt, mstart, mlive, mwin;

  task automatic m_latch(int tgt_cfg);
    if ((mctrl & 2) == 0) msts |= 4;
    else if (mlat != 0) msts |= 8;
    else begin mlat = 1; mlcfg = tgt_cfg; mladdr = int'(bus_addr); mldata = int'(bus_wdata); end
  endtask

  task automatic m_operate();
    int tgt;
    tgt = (mlcfg != 0) ? N : mladdr;
    if ((mctrl & 4) == 0) mm[tgt] &= mldata;
    else if ((mctrl & 16) != 0 || mlcfg != 0) mm[tgt] = 255;
    else if ((mctrl & 8) != 0) begin
      for (int k = mladdr & ~15; k < (mladdr & ~15) + 16; k++) mm[k] = 255;
    end else begin
      for (int k = 0; k < N; k++) mm[k] = 255;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mlive = pwr_rst_n ? mm[N] : 255;
      mwin = mlive & 1;
      mctrl = 0; msts = 0; mlat = 0; mcnt = 0; mstart = 0;
    end else begin
      if (bus_valid) begin
        case (bus_space)
          2'd0: if (mwin != 0) begin
                  if (bus_write) m_latch(0);
                  else if ((mctrl & 2) != 0) msts |= 16;
                end
          2'd1: if (bus_write) begin
                  int wd, v;
                  wd = int'(bus_wdata);
                  if ((wd & ~mctrl & 3) == 3) msts |= 1;
                  else begin
                    v = ((wd & 2) != 0) ? (wd & 31) : 0;
                    if ((v & 1) != 0 && mlat == 0) msts |= 2;
                    if ((v & 1) != 0 && (mctrl & 1) == 0) mstart = mcnt;
                    else if ((v & 1) == 0 && (mctrl & 1) != 0) begin
                      if (mcnt - mstart < MINP) msts |= 32;
                      if (mlat != 0) m_operate();
                      mlat = 0;
                    end
                    mctrl = v;
                  end
                end
          2'd2: if (bus_write) m_latch(1);
          default: if (bus_write) msts &= ~int'(bus_wdata);
        endcase
      end
      mcnt++;
    end
    if (!pwr_rst_n) begin
      for (int k = 0; k < N; k++) mm[k] = 255;
      mm[N] = 255;
    end
  end

  function automatic int m_rd();
    case (bus_space)
      2'd0: return (mwin != 0) ? mm[bus_addr] : 0;
      2'd1: return mctrl;
      2'd2: return mlive;
      default: return msts & 63;
    endcase
  endfunction

  function automatic string sp_tag();
    case (bus_space)
      2'd0: return "R8";
      2'd1: return "R3";
      2'd2: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // model comparison on every clock
  always @(negedge clk)
    if (rst_n && pwr_rst_n && !done) chk(int'(bus_rdata), m_rd(), sp_tag());

  task automatic acc(logic [1:0] sp, int ad, int wd);
    @(posedge clk); #4;
    bus_valid = 1; bus_write = 1; bus_space = sp; bus_addr = AW'(ad); bus_wdata = 8'(wd);
    @(posedge clk); #4;
    bus_valid = 0;
  endtask

  task automatic rdc(logic [1:0] sp, int ad, int exp, string tag);
    @(posedge clk); #4;
    bus_valid = 1; bus_write = 0; bus_space = sp; bus_addr = AW'(ad);
    @(negedge clk); #1;
    chk(int'(bus_rdata), exp, tag);
    @(posedge clk); #4;
    bus_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic prog(int ad, int wd, bit cfg, int mode, int hold);
    acc(2'd1, 0, mode | 2);
    acc(cfg ? 2'd2 : 2'd0, ad, wd);
    acc(2'd1, 0, mode | 3);
    idle(hold);
    acc(2'd1, 0, 0);
  endtask

  task automatic warm_reset(bit pwr);
    @(posedge clk); #4;
    rst_n = 0; if (pwr) pwr_rst_n = 0;
    idle(3); #4;
    rst_n = 1; pwr_rst_n = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    warm_reset(1);
    rdc(2'd1, 0, 8'h00, "R1");
    rdc(2'd3, 0, 8'h00, "R1");
    rdc(2'd2, 0, 8'hFF, "R1");
    rdc(2'd0, 0, 8'hFF, "R14");

    prog(5, 8'h5A, 0, 0, MINP);
    rdc(2'd0, 5, 8'h5A, "R8");
    rdc(2'd3, 0, 8'h00, "R7");
    prog(5, 8'h0F, 0, 0, MINP);
    rdc(2'd0, 5, 8'h0A, "R8");
    prog(6, 8'h00, 0, 0, 3);
    rdc(2'd3, 0, 8'h20, "R7");
    rdc(2'd0, 6, 8'h00, "R7");
    acc(2'd3, 0, 8'hFF);
    rdc(2'd3, 0, 8'h00, "R13");

    prog(5, 8'h00, 0, 8'h14, MINP);
    rdc(2'd0, 5, 8'hFF, "R9");
    rdc(2'd0, 6, 8'h00, "R9");

    prog(17, 0, 0, 0, MINP);
    prog(31, 0, 0, 0, MINP);
    prog(32, 0, 0, 0, MINP);
    prog(20, 0, 0, 8'h0C, MINP);
    rdc(2'd0, 17, 8'hFF, "R10");
    rdc(2'd0, 31, 8'hFF, "R10");
    rdc(2'd0, 32, 8'h00, "R10");
    rdc(2'd0, 6, 8'h00, "R10");

    prog(0, 0, 0, 8'h04, MINP);
    rdc(2'd0, 6, 8'hFF, "R11");
    rdc(2'd0, 32, 8'hFF, "R11");

    acc(2'd1, 0, 8'h03);
    rdc(2'd3, 0, 8'h01, "R2");
    rdc(2'd1, 0, 8'h00, "R2");
    acc(2'd1, 0, 8'h02);
    acc(2'd1, 0, 8'h1D);
    rdc(2'd1, 0, 8'h00, "R3");
    acc(2'd1, 0, 8'hFE);
    rdc(2'd1, 0, 8'h1E, "R3");
    acc(2'd1, 0, 8'h00);
    acc(2'd3, 0, 8'hFF);

    acc(2'd0, 9, 8'h00);
    rdc(2'd3, 0, 8'h04, "R4");
    rdc(2'd0, 9, 8'hFF, "R4");
    acc(2'd1, 0, 8'h02);
    acc(2'd0, 9, 8'h33);
    acc(2'd0, 10, 8'h00);
    rdc(2'd0, 9, 8'hFF, "R5");
    rdc(2'd3, 0, 8'h1C, "R5");
    acc(2'd1, 0, 8'h03);
    idle(MINP);
    acc(2'd1, 0, 8'h00);
    rdc(2'd0, 9, 8'h33, "R4");
    rdc(2'd0, 10, 8'hFF, "R4");
    acc(2'd3, 0, 8'hFF);

    acc(2'd1, 0, 8'h02);
    acc(2'd1, 0, 8'h03);
    rdc(2'd3, 0, 8'h02, "R6");
    idle(MINP);
    acc(2'd1, 0, 8'h00);
    rdc(2'd0, 9, 8'h33, "R6");
    acc(2'd3, 0, 8'hFF);

    prog(0, 8'hFE, 1, 0, MINP);
    rdc(2'd2, 0, 8'hFF, "R12");
    warm_reset(0);
    rdc(2'd2, 0, 8'hFE, "R12");
    rdc(2'd0, 9, 8'h00, "R12");
    acc(2'd0, 9, 8'h00);
    rdc(2'd3, 0, 8'h00, "R12");
    prog(0, 8'h00, 1, 8'h04, MINP);
    warm_reset(0);
    rdc(2'd2, 0, 8'hFF, "R9");
    rdc(2'd0, 9, 8'h33, "R14");
    warm_reset(1);
    rdc(2'd0, 9, 8'hFF, "R14");
    finish_run();
  end
endmodule